// File: doc/BRIEF.md
# PLL Relock Sequencer with Clock Mux Parking

This block reprograms the multiplier, predivider and post-scaler of a core PLL without leaving the core unclocked. When it is idle and receives a start pulse with a new configuration word, it first switches the core clock mux to a second, fixed-frequency PLL. It waits for the mux status to confirm that source. It then loads a lock-time value derived from the new predivider and writes the three PLL fields into the configuration register. After the lock timer reports lock, it returns the mux to the main PLL and pulses `done` once the mux status confirms the main source.

The lock timer and the configuration register live inside the block. The clock mux is outside it: the block drives a select line and reads a 3-bit status code. A behavioural mux model, `clk_mux_model`, stands in for the real glitch-free mux.

Top module: `pll_relock_seq`

## Requirements
- R1: After reset the block is idle (`busy`=0, `done`=0) and `mux_sel`=0, which selects the main PLL. `lock_time` is 0 and `cfg_out` equals the reset word with the lock flag (bit 29) reading 1. The mux model reports status 1.
- R2: A start pulse in idle captures `cfg_in`, raises `busy` and sets `mux_sel` to 1 (alternate PLL) on the next clock edge.
- R3: The new fields are written only while `mux_sel`=1 and the mux status reads 2. In the cycle before that write, `lock_time` is loaded with P×250, where P is `cfg_in[13:8]`. `cfg_out` is unchanged until the write.
- R4: A write replaces only M (bits [25:16]), P (bits [13:8]) and S (bits [2:0]). All other stored bits keep their previous value. Bit 29 of `cfg_out` always shows the lock flag and is never written from `cfg_in`.
- R5: The lock flag goes to 0 on every field write. It returns to 1 exactly max(`lock_time`,1) cycles after that write, as the timer counts down by one per clock.
- R6: `mux_sel` returns to 0 only after the lock flag reads 1. `done` is raised only once the mux status reads 1.
- R7: `done` is a single-cycle pulse. With the two-cycle mux model, `done` rises 10+max(P×250,1) clock edges after the edge that samples the start pulse.
- R8: A start pulse while `busy` is 1 is ignored. It neither changes the word that gets written nor causes an extra sequence.
- R9: After any change of select, the mux model reports status 4 for two cycles. It then reports 2 for the alternate PLL or 1 for the main PLL.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Single-cycle request to run a relock with `cfg_in` |
| cfg_in | input | 32 | New configuration word (M [25:16], P [13:8], S [2:0] used) |
| mux_stat | input | 3 | Mux status: 1 main, 2 alternate, 4 switching |
| busy | output | 1 | A relock sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| mux_sel | output | 1 | Core mux select: 0 main PLL, 1 alternate PLL |
| cfg_out | output | 32 | Configuration register; bit 29 is the lock flag |
| lock_time | output | LOCK_W (14) | Lock-time register, P×250 |

## Verification
The embedded assertions check on every cycle the rules that hold across all sequences. The field write happens only while the block is parked on the alternate PLL. The lock flag drops on a write. The mux leaves the alternate source only when locked. `done` is a single pulse. Busy-time starts leave the captured word alone. Bits outside the fields survive a write. The mux model reports a transition after every select change. Only the bench scenarios can show the arithmetic results: the exact P×250 lock value, the lock-flag rise on its exact cycle, the end-to-end latency for a sweep of predividers including 0 and the maximum, and the merged register value after a sequence with unrelated bits set.

// File: rtl/pll_seq_pkg.sv
// Package: field positions of the PLL configuration word, mux status codes
// and the sequencer state type shared by the relock sequencer modules.
// Assumes a 32-bit configuration word.
package pll_seq_pkg;

    localparam int CFG_W         = 32;
    localparam int M_LSB         = 16;
    localparam int M_W           = 10;
    localparam int P_LSB         = 8;
    localparam int P_W           = 6;
    localparam int S_LSB         = 0;
    localparam int S_W           = 3;
    localparam int LOCK_FLAG_BIT = 29;

    localparam logic [CFG_W-1:0] FIELD_MASK =
        (((32'd1 << M_W) - 32'd1) << M_LSB) |
        (((32'd1 << P_W) - 32'd1) << P_LSB) |
        (((32'd1 << S_W) - 32'd1) << S_LSB);

    localparam logic [2:0] MUXST_MAIN  = 3'd1;
    localparam logic [2:0] MUXST_ALT   = 3'd2;
    localparam logic [2:0] MUXST_SWING = 3'd4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PARK,
        SQ_WRITE,
        SQ_LOCK,
        SQ_RETURN
    } seq_state_e;

endpackage

// File: rtl/pll_lock_timer.sv
// Lock timer: holds the lock-time register (predivider x LOCK_MULT) and a
// down-counter started by each field write. The locked flag drops on the
// write and rises when the count reaches zero (at least one cycle later).
// Assumes load and write never occur in the same cycle.
module pll_lock_timer #(
    parameter int P_W       = 6,
    parameter int LOCK_MULT = 250,
    parameter int CNT_W     = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_time,
    input  logic [P_W-1:0]   pdiv,
    input  logic             wr_pulse,
    output logic [CNT_W-1:0] lock_time,
    output logic             locked
);

    logic [CNT_W-1:0] count;

    // Lock-time register: loaded from the pending predivider before the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_time <= '0;
        end else if (load_time) begin
            lock_time <= CNT_W'(pdiv) * CNT_W'(LOCK_MULT);
        end
    end

    // Countdown and locked flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            locked <= 1'b1;
        end else if (wr_pulse) begin
            count  <= lock_time;
            locked <= 1'b0;
        end else if (count != '0) begin
            count <= count - 1'b1;
            if (count == CNT_W'(1)) begin
                locked <= 1'b1;
            end
        end else if (!locked) begin
            locked <= 1'b1;
        end
    end

    a_r5_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !locked);

    a_r5_hold_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && count > CNT_W'(1) && !wr_pulse) |=> !locked);

endmodule

// File: rtl/pll_cfg_reg.sv
// Configuration register: merges the M, P and S fields of a new word on a
// write and keeps every other bit. The lock flag is overlaid on its bit at
// the output and is never stored from the input word.
module pll_cfg_reg
    import pll_seq_pkg::*;
#(
    parameter logic [CFG_W-1:0] CFG_RESET = 32'h00C8_0400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_pulse,
    input  logic [CFG_W-1:0] new_word,
    input  logic             locked,
    output logic [CFG_W-1:0] cfg_out
);

    logic [CFG_W-1:0] cfg_q;

    // Field merge on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr_pulse) begin
            cfg_q <= (cfg_q & ~FIELD_MASK) | (new_word & FIELD_MASK);
        end
    end

    // Read view with the lock flag inserted.
    always_comb begin
        cfg_out                = cfg_q;
        cfg_out[LOCK_FLAG_BIT] = locked;
    end

    a_r4_keep_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> ((cfg_q & ~FIELD_MASK) == ($past(cfg_q) & ~FIELD_MASK)));

    a_r4_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_pulse |=> $stable(cfg_q));

endmodule

// File: rtl/pll_seq_fsm.sv
// Sequencer control: park the mux on the alternate PLL, load lock time,
// write the fields, wait for lock, return the mux, then pulse done.
// Assumes the mux status input follows the select with some delay.
module pll_seq_fsm
    import pll_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic [2:0]       mux_stat,
    input  logic             locked,
    output logic             busy,
    output logic             done,
    output logic             mux_sel,
    output logic             load_time,
    output logic             wr_pulse,
    output logic [CFG_W-1:0] pend_word
);

    seq_state_e state;

    // Step strobes decoded from state.
    always_comb begin
        busy      = (state != SQ_IDLE);
        load_time = (state == SQ_PARK) && (mux_stat == MUXST_ALT);
        wr_pulse  = (state == SQ_WRITE);
    end

    // State, captured word, mux select and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            pend_word <= '0;
            mux_sel   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        pend_word <= cfg_in;
                        mux_sel   <= 1'b1;
                        state     <= SQ_PARK;
                    end
                end
                SQ_PARK: begin
                    if (mux_stat == MUXST_ALT) begin
                        state <= SQ_WRITE;
                    end
                end
                SQ_WRITE: begin
                    state <= SQ_LOCK;
                end
                SQ_LOCK: begin
                    if (locked) begin
                        mux_sel <= 1'b0;
                        state   <= SQ_RETURN;
                    end
                end
                SQ_RETURN: begin
                    if (mux_stat == MUXST_MAIN) begin
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    a_r2_park_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (mux_sel && busy));

    a_r3_write_while_parked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> (mux_sel && mux_stat == MUXST_ALT));

    a_r6_return_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mux_sel) |-> locked);

    a_r6_done_on_main: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mux_sel && mux_stat == MUXST_MAIN));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_ignore_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(pend_word));

endmodule

// File: rtl/clk_mux_model.sv
// Behavioural clock mux: after any select change it reports the switching
// code for TRANS_CYC cycles, then the code of the selected source.
// Not a real glitch-free mux; used to close the loop around the sequencer.
module clk_mux_model
    import pll_seq_pkg::*;
#(
    parameter int TRANS_CYC = 2,
    localparam int TC_W     = $clog2(TRANS_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    output logic [2:0] stat
);

    logic            cur;
    logic [TC_W-1:0] tcnt;

    // Track the select and time the transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= 1'b0;
            tcnt <= '0;
        end else if (sel != cur) begin
            cur  <= sel;
            tcnt <= TC_W'(TRANS_CYC);
        end else if (tcnt != '0) begin
            tcnt <= tcnt - 1'b1;
        end
    end

    // Status code.
    always_comb begin
        if (tcnt != '0)  stat = MUXST_SWING;
        else if (cur)    stat = MUXST_ALT;
        else             stat = MUXST_MAIN;
    end

    a_r9_swing_after_change: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != cur) |=> (stat == MUXST_SWING));

endmodule

// File: rtl/pll_relock_seq.sv
// Top: PLL relock sequencer. Connects the control FSM, the lock timer and
// the configuration register. The clock mux is external; its select is
// driven here and its 3-bit status is read back.
module pll_relock_seq
    import pll_seq_pkg::*;
#(
    parameter int               LOCK_MULT = 250,
    parameter logic [CFG_W-1:0] CFG_RESET = 32'h00C8_0400,
    localparam int              LOCK_W    = $clog2(((1 << P_W) - 1) * LOCK_MULT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CFG_W-1:0]  cfg_in,
    input  logic [2:0]        mux_stat,
    output logic              busy,
    output logic              done,
    output logic              mux_sel,
    output logic [CFG_W-1:0]  cfg_out,
    output logic [LOCK_W-1:0] lock_time
);

    logic             locked;
    logic             load_time;
    logic             wr_pulse;
    logic [CFG_W-1:0] pend_word;

    pll_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_in    (cfg_in),
        .mux_stat  (mux_stat),
        .locked    (locked),
        .busy      (busy),
        .done      (done),
        .mux_sel   (mux_sel),
        .load_time (load_time),
        .wr_pulse  (wr_pulse),
        .pend_word (pend_word)
    );

    pll_lock_timer #(
        .P_W       (P_W),
        .LOCK_MULT (LOCK_MULT),
        .CNT_W     (LOCK_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_time (load_time),
        .pdiv      (pend_word[P_LSB +: P_W]),
        .wr_pulse  (wr_pulse),
        .lock_time (lock_time),
        .locked    (locked)
    );

    pll_cfg_reg #(
        .CFG_RESET (CFG_RESET)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pulse (wr_pulse),
        .new_word (pend_word),
        .locked   (locked),
        .cfg_out  (cfg_out)
    );

endmodule

// File: tb/pll_relock_seq_tb.sv
// Bench: sweeps predivider values, checks timing and register contents
// against values computed from the requirements.
module pll_relock_seq_tb;
    import pll_seq_pkg::*;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RST_WORD   = 32'h00C8_0400;
    localparam logic [31:0] LOCK_BIT   = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_in = '0;
    logic [2:0]  mux_stat;
    logic        busy, done, mux_sel;
    logic [31:0] cfg_out;
    logic [13:0] lock_time;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [31:0] exp_cfg = RST_WORD;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_relock_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
        .mux_stat(mux_stat), .busy(busy), .done(done), .mux_sel(mux_sel),
        .cfg_out(cfg_out), .lock_time(lock_time)
    );

    clk_mux_model u_mux (
        .clk(clk), .rst_n(rst_n), .sel(mux_sel), .stat(mux_stat)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One relock; optionally pulses start again while busy (R8).
    task automatic run_seq(input logic [31:0] word, input bit intrude);
        int lt, lk, exp_n, n;
        bit got;
        logic [31:0] prev;
        lt    = int'(word[13:8]) * 250;
        lk    = (lt < 1) ? 1 : lt;
        exp_n = 10 + lk;
        prev  = exp_cfg | LOCK_BIT;
        @(negedge clk);
        start  = 1'b1;
        cfg_in = word;
        @(posedge clk);
        @(negedge clk);
        start  = 1'b0;
        cfg_in = ~word;
        check(mux_sel && busy, "R2 park after start", {30'd0, busy, mux_sel}, 32'd3);
        n = 0;
        got = 0;
        while (!got && n < exp_n + 20) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1 || n == 2)
                check(mux_stat == MUXST_SWING, "R9 switching code", 32'(mux_stat), 32'd4);
            if (n == 3) begin
                check(mux_stat == MUXST_ALT, "R9 alternate code", 32'(mux_stat), 32'd2);
                if (intrude) begin
                    start  = 1'b1;
                    cfg_in = 32'hFFFF_FFFF;
                end
            end
            if (n == 4) begin
                start = 1'b0;
                check(cfg_out == prev, "R3 no write before park", cfg_out, prev);
            end
            if (n == 5) begin
                check(lock_time == 14'(lt), "R3 lock time P*250", 32'(lock_time), 32'(lt));
                check(cfg_out[29] == 1'b0, "R5 lock cleared on write", 32'(cfg_out[29]), 32'd0);
            end
            if (n == 4 + lk && lk > 1)
                check(cfg_out[29] == 1'b0, "R5 still unlocked", 32'(cfg_out[29]), 32'd0);
            if (n == 5 + lk)
                check(cfg_out[29] == 1'b1, "R5 locked on time", 32'(cfg_out[29]), 32'd1);
            if (done) begin
                got = 1;
                check(n == exp_n, "R7 latency", 32'(n), 32'(exp_n));
            end
        end
        if (!got) check(1'b0, "R7 done missing", 32'(n), 32'(exp_n));
        exp_cfg = (exp_cfg & ~FIELD_MASK) | (word & FIELD_MASK);
        check(cfg_out == (exp_cfg | LOCK_BIT), "R4 merged fields", cfg_out, exp_cfg | LOCK_BIT);
        check(!mux_sel && mux_stat == MUXST_MAIN, "R6 back on main",
              {28'd0, mux_sel, mux_stat}, 32'd1);
        @(posedge clk);
        @(negedge clk);
        check(!done && !busy, "R7 done single pulse", {30'd0, done, busy}, 32'd0);
        if (intrude) begin
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (done || busy || mux_sel)
                    check(1'b0, "R8 extra sequence", {29'd0, done, busy, mux_sel}, 32'd0);
            end
            check(cfg_out == (exp_cfg | LOCK_BIT), "R8 busy start ignored", cfg_out,
                  exp_cfg | LOCK_BIT);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            failures++;
            $display("FAIL R7 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(!busy && !done, "R1 idle", {30'd0, busy, done}, 32'd0);
        check(!mux_sel && mux_stat == MUXST_MAIN, "R1 main source",
              {28'd0, mux_sel, mux_stat}, 32'd1);
        check(cfg_out == (RST_WORD | LOCK_BIT), "R1 reset word", cfg_out, RST_WORD | LOCK_BIT);
        check(lock_time == '0, "R1 lock time zero", 32'(lock_time), 32'd0);
        for (int p = 0; p < 8; p++) begin
            logic [31:0] w;
            w = 32'hC000_0000 | (32'(p) << 26) | (32'(100 + 17 * p) << 16)
              | (32'(p) << 8) | (32'h0000_00F0 >> p) | 32'(p % 8);
            run_seq(w, p == 2);
        end
        run_seq(32'h5BFF_BF7D, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule